// File: doc/BRIEF.md
# Reloadable Periodic Interval Timer

This block raises a level interrupt at a fixed, software-chosen rate. Time is counted in millisecond units. An external strobe, `ms_tick`, marks each millisecond and is high for one clock cycle. Software writes a reload value N through a 32-bit register port. The timer then raises `irq` once every N+1 milliseconds, which is a rate of 1000/(N+1) interrupts per second. The next period starts on its own each time one ends.

Software acknowledges the interrupt by reading the acknowledge register, which always returns zero. A write to the reload register also clears a pending interrupt and starts the period again from zero. A read of the reload register returns the stored value one cycle later, on `reg_rdata`.

The interrupt line is driven by a two-state machine.
- `IRQ_IDLE` moves to `IRQ_ASSERTED` on the transition RAISE, taken when a period ends.
- `IRQ_ASSERTED` returns to `IRQ_IDLE` on the transition CLEAR, taken on an acknowledge read or a reload write.
- In every other case the machine takes HOLD and stays where it is.

Top module: `ivl_timer`

## Requirements
- R1: After reset, `irq` is low, `reg_rdata` is zero and the reload value reads back as zero.
- R2: With reload value N, `irq` rises on the clock edge that samples the (N+1)-th `ms_tick` strobe counted from the last restart.
- R3: When a period ends, the next period starts with no software action, and `irq` stays high until it is cleared.
- R4: The millisecond count advances only on cycles where `ms_tick` is high. Cycles without the strobe have no effect on when the period ends.
- R5: A write to the reload offset (default 0x228) stores `reg_wdata`, lowers `irq` and restarts the period from a count of zero.
- R6: A read of the acknowledge offset (default 0x230) returns zero on `reg_rdata` in the next cycle and lowers `irq`.
- R7: If a period ends in the same cycle as an acknowledge read, `irq` is high afterwards.
- R8: A read of the reload offset returns the stored value on `reg_rdata` in the next cycle. Reads of any other offset return zero, and writes to any other offset change neither the reload value nor the timing.
- R9: A reload value of 0 raises `irq` on every strobe.
- R10: A reload write in the same cycle as a strobe that would end the period restarts the period and does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Level interrupt |

## Verification
Some rules are checked by assertions on every cycle:
- the count never passes the reload value and holds when no strobe arrives;
- a reload write leaves the count at zero and the interrupt low;
- a period end is always followed by a high interrupt, and an acknowledge without a period end by a low one;
- nonzero read data only ever follows a read.

Only the bench's scenarios can show the absolute period lengths, the tie cases between a period end and an acknowledge or a reload write, the behaviour with sparse strobes, and that writes to other offsets are ignored. The bench compares these against a cycle model it builds from the requirements.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [0:0] {
        IRQ_IDLE     = 1'b0,
        IRQ_ASSERTED = 1'b1
    } ivt_irq_state_e;
endpackage

// File: rtl/ivt_regif.sv
`timescale 1ns/1ps
module ivt_regif #(
    parameter int               ADDR_W     = 12,
    parameter int               DATA_W     = 32,
    parameter logic [ADDR_W-1:0] RELOAD_OFS = 12'h228,
    parameter logic [ADDR_W-1:0] ACK_OFS    = 12'h230
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] reload_q,
    output logic              restart,
    output logic              ack
);
    logic reload_hit;
    logic ack_hit;

    assign reload_hit = (reg_addr == RELOAD_OFS);
    assign ack_hit    = (reg_addr == ACK_OFS);
    assign restart    = reg_wr && reload_hit;
    assign ack        = reg_rd && ack_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (restart) begin
            reload_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd && reload_hit) begin
            reg_rdata <= reload_q;
        end else begin
            reg_rdata <= '0;
        end
    end

    // R8: nonzero read data only follows a read request
    assert_rdata_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata != '0) |-> $past(reg_rd));

    // R5: a reload write is captured into the reload register
    assert_reload_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (reload_q == $past(reg_wdata)));
endmodule

// File: rtl/ivt_ms_counter.sv
`timescale 1ns/1ps
module ivt_ms_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    output logic             period_end
);
    logic [CNT_W-1:0] ms_cnt;

    assign period_end = ms_tick && !restart && (ms_cnt == reload);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_cnt <= '0;
        end else if (restart) begin
            ms_cnt <= '0;
        end else if (ms_tick) begin
            if (ms_cnt == reload) begin
                ms_cnt <= '0;
            end else begin
                ms_cnt <= ms_cnt + 1'b1;
            end
        end
    end

    // R4: without a strobe or restart the count holds
    assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_tick && !restart) |=> $stable(ms_cnt));

    // R5: a restart leaves the count at zero
    assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ms_cnt == '0));

    // R2: the count never runs past the reload value
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ms_cnt <= reload);
endmodule

// File: rtl/ivt_irq_fsm.sv
`timescale 1ns/1ps
module ivt_irq_fsm
    import ivt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic period_end,
    input  logic ack,
    input  logic restart,
    output logic irq
);
    ivt_irq_state_e state_q;
    ivt_irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (period_end) state_d = IRQ_ASSERTED;              // RAISE
            end
            IRQ_ASSERTED: begin
                if (!period_end && (ack || restart)) state_d = IRQ_IDLE; // CLEAR
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_ASSERTED);
    end

    // R2 / R7: a period end always leaves the interrupt high
    assert_raise_on_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> irq);

    // R6: an acknowledge with no period end leaves the interrupt low
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !period_end) |=> !irq);

    // R5: a reload write leaves the interrupt low
    assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !irq);

    // R3: the interrupt only rises on a period end
    assert_rise_needs_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(period_end));
endmodule

// File: rtl/ivl_timer.sv
`timescale 1ns/1ps
module ivl_timer #(
    parameter int               ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] RELOAD_OFS = 12'h228,
    parameter logic [ADDR_W-1:0] ACK_OFS    = 12'h230
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ms_tick,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [ivt_pkg::DATA_W-1:0]  reg_wdata,
    output logic [ivt_pkg::DATA_W-1:0]  reg_rdata,
    output logic                        irq
);
    localparam int DW = ivt_pkg::DATA_W;

    logic [DW-1:0] reload_q;
    logic          restart;
    logic          ack;
    logic          period_end;

    ivt_regif #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DW),
        .RELOAD_OFS (RELOAD_OFS),
        .ACK_OFS    (ACK_OFS)
    ) regif_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reload_q  (reload_q),
        .restart   (restart),
        .ack       (ack)
    );

    ivt_ms_counter #(
        .CNT_W (DW)
    ) counter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ms_tick    (ms_tick),
        .restart    (restart),
        .reload     (reload_q),
        .period_end (period_end)
    );

    ivt_irq_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_end (period_end),
        .ack        (ack),
        .restart    (restart),
        .irq        (irq)
    );
endmodule

// File: tb/ivl_timer_tb_top.sv
`timescale 1ns/1ps
module ivl_timer_tb_top;
    localparam logic [11:0] A_RELOAD = 12'h228;
    localparam logic [11:0] A_ACK    = 12'h230;
    localparam logic [11:0] A_OTHER  = 12'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic        exp_irq_q[$];
    logic [31:0] exp_rd_q[$];
    string       exp_tag_q[$];

    logic [31:0] m_cnt = '0;
    logic [31:0] m_reload = '0;
    logic        m_irq = 1'b0;

    always #2 clk = ~clk;

    ivl_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected outcome
    task automatic step(input logic wr, input logic rd, input logic [11:0] addr,
                        input logic [31:0] wdata, input logic tick, input string tag);
        logic wr_rel;
        logic ack;
        logic fin;
        logic [31:0] erd;
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = wdata; ms_tick = tick;
        wr_rel = wr && (addr == A_RELOAD);
        ack    = rd && (addr == A_ACK);
        fin    = tick && !wr_rel && (m_cnt == m_reload);
        erd    = (rd && addr == A_RELOAD) ? m_reload : 32'h0;
        if (wr_rel) begin
            m_reload = wdata;
            m_cnt    = '0;
        end else if (tick) begin
            m_cnt = fin ? 32'h0 : m_cnt + 1;
        end
        if (fin)                m_irq = 1'b1;
        else if (wr_rel || ack) m_irq = 1'b0;
        exp_irq_q.push_back(m_irq);
        exp_rd_q.push_back(erd);
        exp_tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input logic tick, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, A_OTHER, 32'h0, tick, tag);
    endtask

    // monitor: pops expectations just after the edge
    always @(posedge clk) begin
        #1;
        if (exp_irq_q.size() > 0) begin
            string t;
            t = exp_tag_q.pop_front();
            check({t, " irq"},   {31'h0, irq}, {31'h0, exp_irq_q.pop_front()});
            check({t, " rdata"}, reg_rdata,   exp_rd_q.pop_front());
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset irq",   {31'h0, irq}, 32'h0);
        check("R1 reset rdata", reg_rdata,    32'h0);
        rst_n = 1'b1;
        // R1: reload reads back zero
        step(1'b0, 1'b1, A_RELOAD, 32'h0, 1'b0, "R1");
        idle(1, 1'b0, "R1");
        // R2/R8: reload 3, read back, period of four ticks
        step(1'b1, 1'b0, A_RELOAD, 32'd3, 1'b0, "R5");
        step(1'b0, 1'b1, A_RELOAD, 32'h0, 1'b0, "R8");
        idle(6, 1'b1, "R2");
        // R3: keep running, stays high, next period starts
        idle(8, 1'b1, "R3");
        // R6: acknowledge read
        step(1'b0, 1'b1, A_ACK, 32'h0, 1'b0, "R6");
        idle(2, 1'b0, "R6");
        // R4: sparse strobes
        for (int i = 0; i < 8; i++) begin
            idle(2, 1'b0, "R4");
            idle(1, 1'b1, "R4");
        end
        step(1'b0, 1'b1, A_ACK, 32'h0, 1'b0, "R6");
        // R7: period end coincides with acknowledge
        step(1'b1, 1'b0, A_RELOAD, 32'd1, 1'b0, "R5");
        idle(1, 1'b1, "R7");
        step(1'b0, 1'b1, A_ACK, 32'h0, 1'b1, "R7");
        idle(1, 1'b0, "R7");
        step(1'b0, 1'b1, A_ACK, 32'h0, 1'b0, "R6");
        // R10: reload write on the ending strobe
        step(1'b1, 1'b0, A_RELOAD, 32'd2, 1'b0, "R5");
        idle(2, 1'b1, "R10");
        step(1'b1, 1'b0, A_RELOAD, 32'd2, 1'b1, "R10");
        idle(4, 1'b1, "R10");
        // R5: reload write clears a pending interrupt
        step(1'b1, 1'b0, A_RELOAD, 32'd5, 1'b0, "R5");
        idle(2, 1'b1, "R5");
        // R9: reload zero fires every strobe
        step(1'b1, 1'b0, A_RELOAD, 32'd0, 1'b0, "R9");
        idle(1, 1'b1, "R9");
        step(1'b0, 1'b1, A_ACK, 32'h0, 1'b0, "R9");
        idle(1, 1'b1, "R9");
        step(1'b0, 1'b1, A_ACK, 32'h0, 1'b1, "R9");
        // R8: other offsets ignored
        step(1'b0, 1'b1, A_ACK, 32'h0, 1'b0, "R6");
        step(1'b1, 1'b0, A_RELOAD, 32'd4, 1'b0, "R5");
        idle(2, 1'b1, "R8");
        step(1'b1, 1'b0, A_OTHER, 32'd0, 1'b1, "R8");
        step(1'b0, 1'b1, A_OTHER, 32'h0, 1'b1, "R8");
        step(1'b0, 1'b1, A_RELOAD, 32'h0, 1'b1, "R8");
        idle(6, 1'b1, "R8");
        idle(2, 1'b0, "R8");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule